// File: doc/BRIEF.md
# Lock-Protected Cycle Counter

This block is a memory-mapped free-running cycle counter that sits behind a simple 32-bit register bus made of an address, a write strobe, write data and registered read data. Software first sets a trace-enable gate in a debug control word. Until that gate is set, every counter register reads as zero and ignores writes. Software then writes a fixed unlock key into a lock register. Until the key is written, the control and count registers cannot be changed. A lock status word reports whether the unit is open.

Once the unit is open, software sets the enable bit in the control register and the count register advances by one on every clock. Back-to-back reads therefore show rising values, and the difference between two reads gives the elapsed cycles. While the unit is open, software can also preset or clear the count. The count wraps modulo 2^32. Clearing the gate freezes the count and keeps its value, so counting resumes from that value when the gate is set again.

Top module: `cyccnt_unit`

## Requirements
- R1: After reset the debug control word reads 0, the lock status word reads 0x3, the control register reads 0x40000000 and the count reads 0. Each value is seen once the gate is set.
- R2: While the gate is clear, reads of the control register (offset 0x000), the count register (0x004) and the lock status word (0xFB4) return 0. Writes to these registers and to the lock register are ignored.
- R3: The debug control word sits at offset 0xDFC. Bit 24 is the trace-enable gate and is always readable and writable. All other bits of that word read 0.
- R4: The lock status word at offset 0xFB4 reads 0x3 while the unit is locked and 0x1 while it is open.
- R5: Writing 0xC5ACCE55 to the lock register at offset 0xFB0 opens the unit. Any other value written there, including a value that differs from the key in a single bit, leaves the unit locked or locks it again. The lock register itself reads 0.
- R6: The control register holds the counter enable in bit 0, and bit 30 always reads 1. While the unit is locked, a write to the control register leaves it unchanged.
- R7: While the gate and the enable are both set, the count rises by exactly one per clock. Read data appears one cycle after the address and shows the count held at that sampling edge.
- R8: While the unit is open and the gate is set, a write to the count register loads the written value. The load takes priority over that cycle's increment, and the count wraps from 0xFFFFFFFF to 0. While the unit is locked, such a write is ignored.
- R9: Clearing the gate stops the count and keeps its value. Setting the gate again resumes counting from the kept value.
- R10: Offsets that map to no register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |

## Verification
A write takes effect at the rising edge that samples it. Read data for an address appears after the following rising edge. A count increment first shows at the edge after the enable or the gate was written. The bench drives every access on a falling edge and samples read data on the next falling edge. This lets it predict exact count values: it loads a known value with the counter stopped, or it counts the edges between a load or gate change and the read. Elapsed-cycle checks compare pairs of reads separated by a known number of idle edges.

// File: rtl/cyccnt_pkg.sv
package cyccnt_pkg;

  localparam logic [31:0] UNLOCK_KEY  = 32'hC5AC_CE55;
  localparam logic [31:0] STAT_LOCKED = 32'h0000_0003;
  localparam logic [31:0] STAT_OPEN   = 32'h0000_0001;

  typedef enum logic {
    LK_SHUT = 1'b0,
    LK_OPEN = 1'b1
  } lock_state_e;

  typedef struct packed {
    logic dbg;
    logic ctrl;
    logic cnt;
    logic key;
  } wr_sel_t;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_CTRL,
    RS_CNT,
    RS_STAT,
    RS_DBG
  } rd_sel_e;

endpackage

// File: rtl/cyccnt_regdec.sv
module cyccnt_regdec
  import cyccnt_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 'h000,
  parameter logic [ADDR_W-1:0] OFS_CNT  = 'h004,
  parameter logic [ADDR_W-1:0] OFS_KEY  = 'hFB0,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'hFB4,
  parameter logic [ADDR_W-1:0] OFS_DBG  = 'hDFC
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output wr_sel_t           wsel,
  output rd_sel_e           rsel
);

  // Write strobes: one hot at most, qualified by the bus write strobe.
  always_comb begin
    wsel      = '0;
    wsel.dbg  = we && (addr == OFS_DBG);
    wsel.ctrl = we && (addr == OFS_CTRL);
    wsel.cnt  = we && (addr == OFS_CNT);
    wsel.key  = we && (addr == OFS_KEY);
  end

  // Read select: the lock register is write only and decodes to nothing.
  always_comb begin
    if (addr == OFS_CTRL)      rsel = RS_CTRL;
    else if (addr == OFS_CNT)  rsel = RS_CNT;
    else if (addr == OFS_STAT) rsel = RS_STAT;
    else if (addr == OFS_DBG)  rsel = RS_DBG;
    else                       rsel = RS_NONE;
  end

endmodule

// File: rtl/cyccnt_lock.sv
module cyccnt_lock
  import cyccnt_pkg::*;
#(
  parameter int              DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY  = UNLOCK_KEY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);

  lock_state_e state_q;
  lock_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (key_we) begin
      state_d = (wdata == KEY) ? LK_OPEN : LK_SHUT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LK_SHUT;
    else     state_q <= state_d;
  end

  assign unlocked = (state_q == LK_OPEN);

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
    (key_we && wdata == KEY) |=> unlocked); // R5
  AST_BAD_KEY_SHUTS: assert property (@(posedge clk) disable iff (rst)
    (key_we && wdata != KEY) |=> !unlocked); // R5
  AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (rst)
    !key_we |=> $stable(unlocked)); // R5

endmodule

// File: rtl/cyccnt_counter.sv
module cyccnt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;

  // A load wins over the increment of the same cycle; the sum wraps naturally.
  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (load) count_q <= load_val;
    else if (run)  count_q <= count_q + ONE;
  end

  assign count = count_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> (count == $past(count) + ONE)); // R7
  AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count)); // R9
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val))); // R8

endmodule

// File: rtl/cyccnt_unit.sv
module cyccnt_unit
  import cyccnt_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int GATE_BIT = 24,
  parameter int ID_BIT   = 30,
  parameter int EN_BIT   = 0,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 'h000,
  parameter logic [ADDR_W-1:0] OFS_CNT  = 'h004,
  parameter logic [ADDR_W-1:0] OFS_KEY  = 'hFB0,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'hFB4,
  parameter logic [ADDR_W-1:0] OFS_DBG  = 'hDFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam logic [DATA_W-1:0] ID_MASK   = DATA_W'(1) << ID_BIT;
  localparam logic [DATA_W-1:0] GATE_MASK = DATA_W'(1) << GATE_BIT;

  wr_sel_t           wsel;
  rd_sel_e           rsel;
  logic              gate_q;
  logic              ctrl_en_q;
  logic              unlocked;
  logic              cnt_load;
  logic              cnt_run;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] dbg_word;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  cyccnt_regdec #(
    .ADDR_W  (ADDR_W),
    .OFS_CTRL(OFS_CTRL),
    .OFS_CNT (OFS_CNT),
    .OFS_KEY (OFS_KEY),
    .OFS_STAT(OFS_STAT),
    .OFS_DBG (OFS_DBG)
  ) u_regdec (
    .addr(bus_addr),
    .we  (bus_we),
    .wsel(wsel),
    .rsel(rsel)
  );

  cyccnt_lock #(
    .DATA_W(DATA_W),
    .KEY   (DATA_W'(UNLOCK_KEY))
  ) u_lock (
    .clk     (clk),
    .rst     (rst),
    .key_we  (wsel.key && gate_q),
    .wdata   (bus_wdata),
    .unlocked(unlocked)
  );

  // Global trace gate: lives outside the unit's own gating.
  always_ff @(posedge clk) begin
    if (rst)           gate_q <= 1'b0;
    else if (wsel.dbg) gate_q <= bus_wdata[GATE_BIT];
  end

  // Control enable: needs both the gate and the unlock.
  always_ff @(posedge clk) begin
    if (rst)                                 ctrl_en_q <= 1'b0;
    else if (wsel.ctrl && gate_q && unlocked) ctrl_en_q <= bus_wdata[EN_BIT];
  end

  assign cnt_load = wsel.cnt && gate_q && unlocked;
  assign cnt_run  = gate_q && ctrl_en_q;

  cyccnt_counter #(
    .CNT_W(DATA_W)
  ) u_counter (
    .clk     (clk),
    .rst     (rst),
    .run     (cnt_run),
    .load    (cnt_load),
    .load_val(bus_wdata),
    .count   (count)
  );

  always_comb begin
    ctrl_word = ID_MASK;
    ctrl_word[EN_BIT] = ctrl_en_q;
    dbg_word  = gate_q ? GATE_MASK : '0;
    stat_word = unlocked ? DATA_W'(STAT_OPEN) : DATA_W'(STAT_LOCKED);
  end

  always_comb begin
    rd_mux = '0;
    case (rsel)
      RS_DBG:  rd_mux = dbg_word;
      RS_CTRL: rd_mux = gate_q ? ctrl_word : '0;
      RS_CNT:  rd_mux = gate_q ? count     : '0;
      RS_STAT: rd_mux = gate_q ? stat_word : '0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  AST_GATED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!gate_q && bus_addr != OFS_DBG) |=> (bus_rdata == '0)); // R2
  AST_STAT_CODES: assert property (@(posedge clk) disable iff (rst)
    (gate_q && bus_addr == OFS_STAT) |=>
      (bus_rdata == DATA_W'(STAT_LOCKED) || bus_rdata == DATA_W'(STAT_OPEN))); // R4
  AST_CTRL_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && bus_we && bus_addr == OFS_CTRL) |=> $stable(ctrl_en_q)); // R6
  AST_DBG_OTHER_BITS: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFS_DBG) |=> ((bus_rdata & ~GATE_MASK) == '0)); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != OFS_DBG && bus_addr != OFS_CTRL && bus_addr != OFS_CNT &&
     bus_addr != OFS_STAT) |=> (bus_rdata == '0)); // R10

endmodule

// File: tb/cyccnt_unit_bench.sv
module cyccnt_unit_bench;

  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_CNT  = 12'h004;
  localparam logic [11:0] A_KEY  = 12'hFB0;
  localparam logic [11:0] A_STAT = 12'hFB4;
  localparam logic [11:0] A_DBG  = 12'hDFC;
  localparam logic [31:0] KEY    = 32'hC5AC_CE55;
  localparam logic [31:0] GATE   = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cyccnt_unit u_cyccnt_unit (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    bus_addr = 12'h100;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1 rdata after reset", bus_rdata, 32'h0);

    // Gate clear: everything reads zero, writes dropped.
    rd(A_DBG, v);  check("R1 dbg reset", v, 32'h0);
    rd(A_CTRL, v); check("R2 ctrl gated", v, 32'h0);
    rd(A_CNT, v);  check("R2 cnt gated", v, 32'h0);
    rd(A_STAT, v); check("R2 stat gated", v, 32'h0);
    wr(A_KEY, KEY);

    wr(A_DBG, 32'hFFFF_FFFF);
    rd(A_DBG, v);  check("R3 dbg only gate bit", v, GATE);
    rd(A_STAT, v); check("R2 key ignored while gated", v, 32'h3);
    rd(A_CTRL, v); check("R1 ctrl reset", v, 32'h4000_0000);
    rd(A_CNT, v);  check("R1 cnt reset", v, 32'h0);

    // Locked writes ignored.
    wr(A_CTRL, 32'h4000_0001);
    rd(A_CTRL, v); check("R6 ctrl locked", v, 32'h4000_0000);
    rd(A_CNT, v);  check("R6 cnt idle", v, 32'h0);
    wr(A_CNT, 32'h0000_1234);
    rd(A_CNT, v);  check("R8 cnt locked", v, 32'h0);

    // Single-bit key corruptions keep the unit locked.
    for (int bt = 0; bt < 32; bt++) begin
      wr(A_KEY, KEY ^ (32'h1 << bt));
      rd(A_STAT, v); check($sformatf("R5 near key bit %0d", bt), v, 32'h3);
    end

    wr(A_KEY, KEY);
    rd(A_STAT, v); check("R4 stat open", v, 32'h1);
    rd(A_KEY, v);  check("R5 key reads zero", v, 32'h0);

    // Enable and count.
    wr(A_CTRL, 32'h4000_0001);
    rd(A_CNT, v); check("R7 first read", v, 32'd0);
    rd(A_CNT, v); check("R7 second read", v, 32'd1);
    rd(A_CNT, v); check("R7 third read", v, 32'd2);
    rd(A_CTRL, v); check("R6 ctrl open", v, 32'h4000_0001);

    for (int g = 0; g < 8; g++) begin
      rd(A_CNT, a); idle(g); rd(A_CNT, b);
      check($sformatf("R7 gap %0d", g), b - a, 32'(g + 1));
    end

    // Preset and wrap.
    wr(A_CTRL, 32'h4000_0000);
    wr(A_CNT, 32'hFFFF_FFFE);
    rd(A_CNT, v); check("R8 preset", v, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h4000_0001);
    rd(A_CNT, v); check("R8 wrap a", v, 32'hFFFF_FFFE);
    rd(A_CNT, v); check("R8 wrap b", v, 32'hFFFF_FFFF);
    rd(A_CNT, v); check("R8 wrap c", v, 32'h0000_0000);
    rd(A_CNT, v); check("R8 wrap d", v, 32'h0000_0001);

    // Load beats increment while running.
    wr(A_CNT, 32'h0000_0100);
    rd(A_CNT, v); check("R8 load over run", v, 32'h100);
    rd(A_CNT, v); check("R8 after load", v, 32'h101);

    // Gate freeze and retention.
    wr(A_CNT, 32'd100);
    wr(A_DBG, 32'h0);
    idle(5);
    rd(A_CNT, v);  check("R2 cnt zero gate off", v, 32'h0);
    rd(A_CTRL, v); check("R2 ctrl zero gate off", v, 32'h0);
    rd(A_STAT, v); check("R2 stat zero gate off", v, 32'h0);
    wr(A_CNT, 32'd7);
    wr(A_CTRL, 32'h4000_0000);
    wr(A_DBG, GATE);
    rd(A_CNT, v); check("R9 kept count", v, 32'd101);
    rd(A_CNT, v); check("R9 resumed", v, 32'd102);

    // Relock.
    wr(A_KEY, 32'h0);
    rd(A_STAT, v); check("R5 relock", v, 32'h3);
    wr(A_CTRL, 32'h4000_0000);
    rd(A_CTRL, v); check("R6 ctrl locked again", v, 32'h4000_0001);

    // Unmapped.
    rd(12'h008, v); check("R10 unmapped 008", v, 32'h0);
    rd(12'hFFC, v); check("R10 unmapped FFC", v, 32'h0);
    rd(12'h100, v); check("R10 unmapped 100", v, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule